// File: doc/BRIEF.md
# Block Transfer Handshake Controller

This controller decides the moment at which a block of outgoing characters, already assembled by an upstream queue, may be released toward the host. A transfer request comes from the operator's send key or from a second request line used by machine-initiated transfers such as escape-sequence reads, status replies and cursor-position replies. Both sources follow the same handshake.

Two configuration bits choose the discipline. With handshaking inhibited the block is freed at once. In trigger mode the controller waits for the host to send a DC1 control character. In request-grant mode it first sends a DC2 control character to the host as a request to send, then waits for the host's DC1 grant. The controller only sequences these control characters and the one-cycle release strobe. It does not build the block and does not drive the serial line.

Top module: `blk_handshake_ctrl`

## Requirements
- R1: With `cfg_inhibit_hs_i`=1, an accepted request raises `release_o` in the next cycle, and `tx_valid_o` stays 0.
- R2: With `cfg_inhibit_hs_i`=0 and `cfg_inhibit_dc2_i`=1 (trigger mode), an accepted request sends no byte and waits. `release_o` rises in the cycle after a received byte matching DC1 (0x11). Other received bytes, for example 0x13, are ignored.
- R3: With both configuration bits 0 (request-grant mode), `tx_valid_o`=1 with `tx_byte_o`=0x12 (DC2) appears in the cycle after an accepted request. The byte is held, with no release, until a cycle with `tx_ready_i`=1. A DC1 received before that cycle is ignored. After the handshake `tx_valid_o` drops, and a later DC1 releases the block as in R2.
- R4: The discipline is fixed when a request is accepted. Changing the configuration bits while waiting does not change how the pending request finishes.
- R5: `host_req_i` is accepted exactly as `send_key_i` is.
- R6: A DC1 received while idle is ignored and does not pre-arm a later release.
- R7: Requests that arrive while a transfer is pending are ignored, and each accepted request yields exactly one release pulse.
- R8: `release_o` is a single-cycle pulse, after which the controller is idle (a further DC1 has no effect).
- R9: `abort_i` returns the controller to idle in the next cycle from any state (no `tx_valid_o`, no `release_o`). It wins over a request or a DC1 in the same cycle.
- R10: A request is accepted only while `blk_ready_i`=1. Otherwise it is ignored.
- R11: With the default `IGNORE_MSB`=1, the DC1 comparison ignores the top data bit, so 0x91 also acts as the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_i | input | 1 | Return to idle |
| cfg_inhibit_hs_i | input | 1 | 1 = no handshake |
| cfg_inhibit_dc2_i | input | 1 | 1 = no DC2 request (trigger mode when handshake is enabled) |
| send_key_i | input | 1 | Send key strobe |
| host_req_i | input | 1 | Machine-initiated transfer request |
| blk_ready_i | input | 1 | Upstream queue holds a block |
| rx_valid_i | input | 1 | Received byte valid |
| rx_byte_i | input | DATA_W | Received byte |
| tx_ready_i | input | 1 | Transmitter accepts the control byte |
| tx_valid_o | output | 1 | Control byte valid |
| tx_byte_o | output | DATA_W | Control byte (DC2) |
| release_o | output | 1 | One-cycle block release strobe |

## Verification
The clash of interest is `abort_i` arriving in the same cycle as an event that would advance the controller. The bench provokes it in three forms: together with the DC1 grant while waiting, during the pending DC2 transmission, and together with a fresh request while idle. In each case it requires no release and no control byte in the following cycle. It then feeds another DC1 to show that nothing stayed armed. A second overlap is a DC1 received during the same stretch in which the DC2 is still held by backpressure. This is judged by the absence of a release until the handshake has completed.

// File: rtl/blkhs_pkg.sv
package blkhs_pkg;
   typedef enum logic [1:0] {
      HS_NONE     = 2'd0,
      HS_TRIG     = 2'd1,
      HS_REQGRANT = 2'd2
   } hs_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SEND  = 2'd1,
      ST_WAIT  = 2'd2,
      ST_FREE  = 2'd3
   } hs_state_e;
endpackage

// File: rtl/blkhs_mode_dec.sv
module blkhs_mode_dec
   import blkhs_pkg::*;
(
   input  logic     inhibit_hs,
   input  logic     inhibit_dc2,
   output hs_mode_e mode
);
   always_comb begin
      if (inhibit_hs)       mode = HS_NONE;
      else if (inhibit_dc2) mode = HS_TRIG;
      else                  mode = HS_REQGRANT;
   end
endmodule

// File: rtl/blkhs_code_match.sv
module blkhs_code_match #(
   parameter int          DATA_W     = 8,
   parameter logic [7:0]  CODE       = 8'h11,
   parameter bit          IGNORE_MSB = 1'b1
) (
   input  logic              valid,
   input  logic [DATA_W-1:0] data,
   output logic              hit
);
   localparam logic [DATA_W-1:0] CODE_W = DATA_W'(CODE);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("blkhs_code_match: DATA_W must be at least 2");
      end
      if (IGNORE_MSB) begin : g_low_bits
         assign hit = valid && (data[DATA_W-2:0] == CODE_W[DATA_W-2:0]);
      end else begin : g_all_bits
         assign hit = valid && (data == CODE_W);
      end
   endgenerate
endmodule

// File: rtl/blkhs_fsm.sv
module blkhs_fsm
   import blkhs_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     abort,
   input  logic     req,
   input  logic     blk_ready,
   input  hs_mode_e mode,
   input  logic     grant_hit,
   input  logic     tx_ready,
   output logic     tx_req,
   output logic     release_pulse
);
   hs_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (req && blk_ready) begin
            unique case (mode)
               HS_NONE: state_d = ST_FREE;
               HS_TRIG: state_d = ST_WAIT;
               default: state_d = ST_SEND;
            endcase
         end
         ST_SEND: if (tx_ready)  state_d = ST_WAIT;
         ST_WAIT: if (grant_hit) state_d = ST_FREE;
         default: state_d = ST_IDLE;
      endcase
      if (abort) state_d = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign tx_req        = (state_q == ST_SEND);
   assign release_pulse = (state_q == ST_FREE);

   // R8: release lasts one cycle
   p_release_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      release_pulse |=> !release_pulse);

   // R9: abort clears outputs next cycle
   p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!release_pulse && !tx_req));

   // R3: DC2 held under backpressure
   p_dc2_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !tx_ready && !abort) |=> (tx_req && !release_pulse));

   // R6: idle DC1 without request does nothing
   p_idle_grant_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_req && !release_pulse && !req && grant_hit && $past(!tx_req) && !abort)
      |=> !tx_req);

   // R1: no-handshake release follows request
   p_nohs_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && req && blk_ready && mode == HS_NONE && !abort)
      |=> release_pulse);
endmodule

// File: rtl/blk_handshake_ctrl.sv
module blk_handshake_ctrl
   import blkhs_pkg::*;
#(
   parameter int         DATA_W     = 8,
   parameter logic [7:0] GRANT_CODE = 8'h11,
   parameter logic [7:0] ASK_CODE   = 8'h12,
   parameter bit         IGNORE_MSB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort_i,
   input  logic              cfg_inhibit_hs_i,
   input  logic              cfg_inhibit_dc2_i,
   input  logic              send_key_i,
   input  logic              host_req_i,
   input  logic              blk_ready_i,
   input  logic              rx_valid_i,
   input  logic [DATA_W-1:0] rx_byte_i,
   input  logic              tx_ready_i,
   output logic              tx_valid_o,
   output logic [DATA_W-1:0] tx_byte_o,
   output logic              release_o
);
   localparam logic [DATA_W-1:0] ASK_W = DATA_W'(ASK_CODE);

   generate
      if (DATA_W < 7 || DATA_W > 8) begin : g_bad_width
         $error("blk_handshake_ctrl: DATA_W must be 7 or 8");
      end
   endgenerate

   hs_mode_e mode;
   logic     grant_hit;
   logic     tx_req;

   blkhs_mode_dec u_mode (
      .inhibit_hs  (cfg_inhibit_hs_i),
      .inhibit_dc2 (cfg_inhibit_dc2_i),
      .mode        (mode)
   );

   blkhs_code_match #(
      .DATA_W     (DATA_W),
      .CODE       (GRANT_CODE),
      .IGNORE_MSB (IGNORE_MSB)
   ) u_grant (
      .valid (rx_valid_i),
      .data  (rx_byte_i),
      .hit   (grant_hit)
   );

   blkhs_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .abort         (abort_i),
      .req           (send_key_i | host_req_i),
      .blk_ready     (blk_ready_i),
      .mode          (mode),
      .grant_hit     (grant_hit),
      .tx_ready      (tx_ready_i),
      .tx_req        (tx_req),
      .release_pulse (release_o)
   );

   assign tx_valid_o = tx_req;
   assign tx_byte_o  = tx_req ? ASK_W : '0;

   // R3: byte stable while presented
   p_tx_byte_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i && !abort_i) |=> (tx_valid_o && $stable(tx_byte_o)));
endmodule

// File: tb/test_blk_handshake_ctrl.sv
`timescale 1ns/1ps
module test_blk_handshake_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       abort_i = 1'b0;
   logic       inh_hs = 1'b0, inh_dc2 = 1'b0;
   logic       send_key = 1'b0, host_req = 1'b0;
   logic       blk_ready = 1'b1;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       tx_ready = 1'b0;
   logic       tx_valid;
   logic [7:0] tx_byte;
   logic       release_s;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   blk_handshake_ctrl i_blk_handshake_ctrl (
      .clk (clk), .rst_n (rst_n), .abort_i (abort_i),
      .cfg_inhibit_hs_i (inh_hs), .cfg_inhibit_dc2_i (inh_dc2),
      .send_key_i (send_key), .host_req_i (host_req), .blk_ready_i (blk_ready),
      .rx_valid_i (rx_valid), .rx_byte_i (rx_byte), .tx_ready_i (tx_ready),
      .tx_valid_o (tx_valid), .tx_byte_o (tx_byte), .release_o (release_s)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse_req(int src);
      if (src == 0) send_key = 1'b1; else host_req = 1'b1;
      tick();
      send_key = 1'b0; host_req = 1'b0;
   endtask

   task automatic rx(logic [7:0] b);
      rx_valid = 1'b1; rx_byte = b;
      tick();
      rx_valid = 1'b0; rx_byte = 8'h00;
   endtask

   task automatic run_case(int msel, int src, int hold, logic [7:0] grant);
      inh_hs = msel[1]; inh_dc2 = msel[0];
      pulse_req(src);
      if (inh_hs) begin
         check("R1/R5 release after request", release_s, 1);
         check("R1 no tx byte", tx_valid, 0);
         tick();
         check("R8 release single cycle", release_s, 0);
      end else if (inh_dc2) begin
         check("R2 waiting no release", release_s, 0);
         check("R2 no tx byte", tx_valid, 0);
         rx(8'h13);
         check("R2 other byte ignored", release_s, 0);
         pulse_req(1 - src);
         check("R7 extra request ignored", release_s, 0);
         rx(grant);
         check("R2/R11 grant releases", release_s, 1);
         tick();
         check("R8 release single cycle", release_s, 0);
         rx(grant);
         check("R8 idle after release", release_s, 0);
      end else begin
         check("R3 DC2 valid", tx_valid, 1);
         check("R3 DC2 code", tx_byte, 8'h12);
         for (int h = 0; h < hold; h++) begin
            rx(8'h11);
            check("R3 DC2 held", tx_valid, 1);
            check("R3 DC2 code held", tx_byte, 8'h12);
            check("R3 early DC1 ignored", release_s, 0);
         end
         tx_ready = 1'b1;
         tick();
         tx_ready = 1'b0;
         check("R3 DC2 done", tx_valid, 0);
         check("R3 no release before grant", release_s, 0);
         pulse_req(1 - src);
         check("R7 request ignored in wait", tx_valid, 0);
         check("R7 no release in wait", release_s, 0);
         rx(grant);
         check("R3/R11 grant releases", release_s, 1);
         tick();
         check("R8 release single cycle", release_s, 0);
      end
      tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) tick();
      check("reset tx_valid", tx_valid, 0);
      check("reset release", release_s, 0);
      check("reset tx_byte", tx_byte, 0);
      rst_n = 1'b1;
      tick();

      for (int m = 0; m < 4; m++)
         for (int s = 0; s < 2; s++)
            for (int h = 0; h < 4; h++)
               for (int g = 0; g < 2; g++)
                  run_case(m, s, h, g ? 8'h91 : 8'h11);

      // R10: no block ready
      inh_hs = 0; inh_dc2 = 0; blk_ready = 1'b0;
      pulse_req(0);
      check("R10 not accepted tx", tx_valid, 0);
      check("R10 not accepted release", release_s, 0);
      inh_hs = 1;
      pulse_req(1);
      check("R10 not accepted nohs", release_s, 0);
      blk_ready = 1'b1;
      tick();

      // R6: DC1 in idle does not pre-arm
      inh_hs = 0; inh_dc2 = 1;
      rx(8'h11);
      check("R6 idle DC1 no release", release_s, 0);
      pulse_req(0);
      check("R6 not pre-armed", release_s, 0);
      rx(8'h11);
      check("R6 later DC1 releases", release_s, 1);
      tick();

      // R4: discipline fixed at acceptance
      inh_hs = 0; inh_dc2 = 1;
      pulse_req(0);
      inh_hs = 1;
      tick();
      check("R4 config change no release", release_s, 0);
      inh_hs = 0; inh_dc2 = 0;
      tick();
      check("R4 no DC2 after switch", tx_valid, 0);
      rx(8'h11);
      check("R4 pending finishes on DC1", release_s, 1);
      tick();

      // R9: abort with grant in same cycle
      inh_hs = 0; inh_dc2 = 1;
      pulse_req(1);
      abort_i = 1'b1; rx_valid = 1'b1; rx_byte = 8'h11;
      tick();
      abort_i = 1'b0; rx_valid = 1'b0;
      check("R9 abort beats grant", release_s, 0);
      rx(8'h11);
      check("R9 idle after abort", release_s, 0);

      // R9: abort during DC2
      inh_dc2 = 0;
      pulse_req(0);
      check("R9 DC2 pending before abort", tx_valid, 1);
      abort_i = 1'b1;
      tick();
      abort_i = 1'b0;
      check("R9 abort drops DC2", tx_valid, 0);
      tick();
      check("R9 stays idle", tx_valid, 0);

      // R9: abort with request in idle
      inh_hs = 1;
      abort_i = 1'b1; send_key = 1'b1;
      tick();
      abort_i = 1'b0; send_key = 1'b0;
      check("R9 abort beats request", release_s, 0);
      tick();
      check("R9 no late release", release_s, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule